// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block models the write-side command interface of a byte-wide parallel NOR flash as synchronous logic. The host bus presents each write as a one-cycle strobe that carries a 20-bit address and a data byte. The decoder matches multi-cycle unlock sequences against the low address bits and the data values. When a sequence completes, it emits one command pulse together with the address and data it latched. The pulse goes to an embedded-operation engine, which this block does not contain.

The decoder has two mode flags. One shows whether the part is in read-array mode or identification (autoselect) mode. The other shows whether a sector erase is suspended. The engine drives a busy input back. While an operation runs, that input stops the decoder from accepting commands, except that a running sector erase can still be suspended.

Top module: `flash_cmd_decoder`

## Requirements
- R1: Every multi-cycle sequence opens with data AAh written where wr_addr[10:0]=555h, followed by data 55h written where wr_addr[10:0]=2AAh. Address bits 19 to 11 are ignored in these comparisons.
- R2: A third write of 90h to 555h raises in_autoselect and pulses code 1. While in_autoselect is high, every write other than F0h is ignored.
- R3: A write of F0h to any address pulses code 0 and clears in_autoselect. It also drops any partly entered sequence, so the next write must restart with the unlock prefix. The one exception is the program-data cycle (see R4).
- R4: After the prefix and A0h written to 555h, the next write of any address and any data pulses code 2 (program) and outputs that address and data. F0h as data is programmed and is not taken as a reset.
- R5: After the prefix and 80h to 555h, a second prefix and then 10h to 555h pulse code 3 (chip erase).
- R6: The same six-cycle erase path ending with 30h at any address pulses code 4 (sector erase). cmd_sector then equals address bits 19:16 of that write.
- R7: A write with an unexpected address or data at any step returns the decoder to idle and produces no pulse. A following correct sequence is still decoded.
- R8: While busy_in is high and the last started operation was a program or chip erase, all writes are ignored, including F0h and B0h.
- R9: While busy_in is high during a sector erase, only B0h at any address is taken. It pulses code 5 and raises erase_suspended. All other writes are ignored.
- R10: While erase_suspended is high and busy_in is low, a single write of 30h at any address pulses code 6 and clears erase_suspended. Program sequences are still decoded in this state. Autoselect and erase setups are aborted.
- R11: Each command pulse lasts one cycle and appears in the cycle after the strobe that completes the sequence. Code encoding: 0 reset, 1 autoselect, 2 program, 3 chip erase, 4 sector erase, 5 suspend, 6 resume.
- R12: rst_n (asynchronous, active low) and soft_clr (synchronous) clear the sequence state, both mode flags and the outputs. soft_clr takes priority over a write strobe in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| soft_clr | input | 1 | Synchronous clear of all decoder state |
| wr_en | input | 1 | One-cycle bus write strobe |
| wr_addr | input | 20 | Write address |
| wr_data | input | 8 | Write data |
| busy_in | input | 1 | Embedded operation in progress |
| cmd_valid | output | 1 | One-cycle command pulse |
| cmd_code | output | 3 | Command code (see R11) |
| cmd_addr | output | 20 | Address of the completing write |
| cmd_data | output | 8 | Data of the completing write |
| cmd_sector | output | 4 | Sector number, address bits 19:16 |
| in_autoselect | output | 1 | Identification mode active |
| erase_suspended | output | 1 | A sector erase is suspended |

## Verification
Two functions can fall in the same cycle: the synchronous clear, and the strobe that completes a sequence. The bench provokes this by raising soft_clr on the same edge as a program-data write. It expects no command pulse, and it expects that a later sequence must start again from the unlock prefix. A second clash is a program-data write of F0h, where the program function must win over the reset function. The bench judges this by the code and the data on the pulse.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
  typedef enum logic [2:0] {
    CMD_RESET    = 3'd0,
    CMD_AUTOSEL  = 3'd1,
    CMD_PROGRAM  = 3'd2,
    CMD_CHIP_ERS = 3'd3,
    CMD_SECT_ERS = 3'd4,
    CMD_SUSPEND  = 3'd5,
    CMD_RESUME   = 3'd6
  } cmd_e;

  typedef enum logic [2:0] {
    SQ_IDLE, SQ_UNLK1, SQ_UNLK2, SQ_PROG, SQ_ERS_SET, SQ_ERS_UNLK1, SQ_ERS_UNLK2
  } seq_e;

  localparam logic [7:0] BYTE_UNLK1   = 8'hAA;
  localparam logic [7:0] BYTE_UNLK2   = 8'h55;
  localparam logic [7:0] BYTE_AUTOSEL = 8'h90;
  localparam logic [7:0] BYTE_PROG    = 8'hA0;
  localparam logic [7:0] BYTE_ERS     = 8'h80;
  localparam logic [7:0] BYTE_CHIP    = 8'h10;
  localparam logic [7:0] BYTE_SECT    = 8'h30;
  localparam logic [7:0] BYTE_RESET   = 8'hF0;
  localparam logic [7:0] BYTE_SUSP    = 8'hB0;
endpackage

// File: rtl/flash_cmd_key_match.sv
module flash_cmd_key_match #(
  parameter int                  KEY_W = 11,
  parameter logic [KEY_W-1:0]    KEY   = 11'h555
) (
  input  logic [KEY_W-1:0] addr_low,
  output logic             hit
);
  always_comb hit = (addr_low == KEY);
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import flash_cmd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       soft_clr,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       hit_a,
  input  logic       hit_b,
  input  logic       busy,
  output logic       evt_v,
  output cmd_e       evt_code,
  output logic       autosel_q,
  output logic       susp_q
);
  seq_e state_q, state_d;
  logic autosel_d, susp_d, run_sect_q, run_sect_d;

  always_comb begin
    state_d    = state_q;
    autosel_d  = autosel_q;
    susp_d     = susp_q;
    run_sect_d = run_sect_q;
    evt_v      = 1'b0;
    evt_code   = CMD_RESET;
    if (soft_clr) begin
      state_d    = SQ_IDLE;
      autosel_d  = 1'b0;
      susp_d     = 1'b0;
      run_sect_d = 1'b0;
    end else if (wr_en) begin
      if (busy) begin
        if (run_sect_q && !susp_q && wr_data == BYTE_SUSP) begin
          evt_v    = 1'b1;
          evt_code = CMD_SUSPEND;
          susp_d   = 1'b1;
        end
      end else if (wr_data == BYTE_RESET && state_q != SQ_PROG) begin
        evt_v     = 1'b1;
        evt_code  = CMD_RESET;
        state_d   = SQ_IDLE;
        autosel_d = 1'b0;
      end else if (!autosel_q) begin
        state_d = SQ_IDLE;
        unique case (state_q)
          SQ_IDLE: begin
            if (susp_q && wr_data == BYTE_SECT) begin
              evt_v      = 1'b1;
              evt_code   = CMD_RESUME;
              susp_d     = 1'b0;
              run_sect_d = 1'b1;
            end else if (hit_a && wr_data == BYTE_UNLK1) begin
              state_d = SQ_UNLK1;
            end
          end
          SQ_UNLK1: if (hit_b && wr_data == BYTE_UNLK2) state_d = SQ_UNLK2;
          SQ_UNLK2: begin
            if (hit_a && wr_data == BYTE_PROG) begin
              state_d = SQ_PROG;
            end else if (hit_a && !susp_q && wr_data == BYTE_ERS) begin
              state_d = SQ_ERS_SET;
            end else if (hit_a && !susp_q && wr_data == BYTE_AUTOSEL) begin
              evt_v     = 1'b1;
              evt_code  = CMD_AUTOSEL;
              autosel_d = 1'b1;
            end
          end
          SQ_PROG: begin
            evt_v      = 1'b1;
            evt_code   = CMD_PROGRAM;
            run_sect_d = 1'b0;
          end
          SQ_ERS_SET:   if (hit_a && wr_data == BYTE_UNLK1) state_d = SQ_ERS_UNLK1;
          SQ_ERS_UNLK1: if (hit_b && wr_data == BYTE_UNLK2) state_d = SQ_ERS_UNLK2;
          SQ_ERS_UNLK2: begin
            if (hit_a && wr_data == BYTE_CHIP) begin
              evt_v      = 1'b1;
              evt_code   = CMD_CHIP_ERS;
              run_sect_d = 1'b0;
            end else if (wr_data == BYTE_SECT) begin
              evt_v      = 1'b1;
              evt_code   = CMD_SECT_ERS;
              run_sect_d = 1'b1;
            end
          end
          default: state_d = SQ_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= SQ_IDLE;
      autosel_q  <= 1'b0;
      susp_q     <= 1'b0;
      run_sect_q <= 1'b0;
    end else begin
      state_q    <= state_d;
      autosel_q  <= autosel_d;
      susp_q     <= susp_d;
      run_sect_q <= run_sect_d;
    end
  end
endmodule

// File: rtl/flash_cmd_out_reg.sv
module flash_cmd_out_reg
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 8,
  parameter int SECT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_clr,
  input  logic              evt_v,
  input  cmd_e              evt_code,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              cmd_valid,
  output cmd_e              cmd_code,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [DATA_W-1:0] cmd_data,
  output logic [SECT_W-1:0] cmd_sector
);
  localparam int SECT_LSB = ADDR_W - SECT_W;

  logic load_en;
  always_comb load_en = evt_v || soft_clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cmd_valid <= 1'b0;
    else        cmd_valid <= evt_v && !soft_clr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_code   <= CMD_RESET;
      cmd_addr   <= '0;
      cmd_data   <= '0;
      cmd_sector <= '0;
    end else if (load_en) begin
      cmd_code   <= soft_clr ? CMD_RESET : evt_code;
      cmd_addr   <= soft_clr ? '0 : wr_addr;
      cmd_data   <= soft_clr ? '0 : wr_data;
      cmd_sector <= soft_clr ? '0 : wr_addr[ADDR_W-1:SECT_LSB];
    end
  end
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 8,
  parameter int SECT_W = 4,
  parameter int KEY_W  = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_clr,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              busy_in,
  output logic              cmd_valid,
  output logic [2:0]        cmd_code,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [DATA_W-1:0] cmd_data,
  output logic [SECT_W-1:0] cmd_sector,
  output logic              in_autoselect,
  output logic              erase_suspended
);
  localparam logic [KEY_W-1:0] KEY_FIRST  = KEY_W'(11'h555);
  localparam logic [KEY_W-1:0] KEY_SECOND = KEY_W'(11'h2AA);

  logic [1:0] rst_sync_q;
  logic       rst_n_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  always_comb rst_n_s = rst_sync_q[1];

  logic hit_a, hit_b, evt_v;
  cmd_e evt_code, code_q;

  flash_cmd_key_match #(.KEY_W(KEY_W), .KEY(KEY_FIRST)) i_key_a (
    .addr_low(wr_addr[KEY_W-1:0]), .hit(hit_a));
  flash_cmd_key_match #(.KEY_W(KEY_W), .KEY(KEY_SECOND)) i_key_b (
    .addr_low(wr_addr[KEY_W-1:0]), .hit(hit_b));

  flash_cmd_seq i_seq (
    .clk(clk), .rst_n(rst_n_s), .soft_clr(soft_clr), .wr_en(wr_en),
    .wr_data(wr_data[7:0]), .hit_a(hit_a), .hit_b(hit_b), .busy(busy_in),
    .evt_v(evt_v), .evt_code(evt_code), .autosel_q(in_autoselect),
    .susp_q(erase_suspended));

  flash_cmd_out_reg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SECT_W(SECT_W)) i_out (
    .clk(clk), .rst_n(rst_n_s), .soft_clr(soft_clr), .evt_v(evt_v),
    .evt_code(evt_code), .wr_addr(wr_addr), .wr_data(wr_data),
    .cmd_valid(cmd_valid), .cmd_code(code_q), .cmd_addr(cmd_addr),
    .cmd_data(cmd_data), .cmd_sector(cmd_sector));

  always_comb cmd_code = code_q;

  assert_pulse_after_strobe_R11: assert property (@(posedge clk) disable iff (!rst_n_s)
    cmd_valid |-> $past(wr_en));
  assert_busy_ignore_R8: assert property (@(posedge clk) disable iff (!rst_n_s)
    (wr_en && busy_in && wr_data[7:0] != BYTE_SUSP) |=> !cmd_valid);
  assert_autosel_entry_R2: assert property (@(posedge clk) disable iff (!rst_n_s)
    $rose(in_autoselect) |-> (cmd_valid && cmd_code == CMD_AUTOSEL));
  assert_autosel_exit_R3: assert property (@(posedge clk) disable iff (!rst_n_s)
    $fell(in_autoselect) |-> ((cmd_valid && cmd_code == CMD_RESET) || $past(soft_clr)));
  assert_suspend_entry_R9: assert property (@(posedge clk) disable iff (!rst_n_s)
    $rose(erase_suspended) |-> (cmd_valid && cmd_code == CMD_SUSPEND));
  assert_resume_exit_R10: assert property (@(posedge clk) disable iff (!rst_n_s)
    $fell(erase_suspended) |-> ((cmd_valid && cmd_code == CMD_RESUME) || $past(soft_clr)));
endmodule

// File: tb/test_flash_cmd_decoder.sv
module test_flash_cmd_decoder;
  typedef struct {
    logic [2:0]  code;
    logic [19:0] addr;
    logic [7:0]  data;
    logic [3:0]  sect;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        soft_clr = 1'b0;
  logic        wr_en = 1'b0;
  logic [19:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        busy_in = 1'b0;
  logic        cmd_valid, in_autoselect, erase_suspended;
  logic [2:0]  cmd_code;
  logic [19:0] cmd_addr;
  logic [7:0]  cmd_data;
  logic [3:0]  cmd_sector;

  int   compared = 0;
  int   mismatched = 0;
  exp_t exq[$];
  exp_t got;
  string phase = "R12";

  always #2.5 clk = ~clk;

  flash_cmd_decoder i_flash_cmd_decoder (
    .clk(clk), .rst_n(rst_n), .soft_clr(soft_clr), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .busy_in(busy_in),
    .cmd_valid(cmd_valid), .cmd_code(cmd_code), .cmd_addr(cmd_addr),
    .cmd_data(cmd_data), .cmd_sector(cmd_sector),
    .in_autoselect(in_autoselect), .erase_suspended(erase_suspended));

  // monitor: every pulse must match the queue head (R11 timing included)
  always @(negedge clk) begin
    if (rst_n && cmd_valid) begin
      compared++;
      if (exq.size() == 0) begin
        mismatched++;
        $display("FAIL %s: unexpected pulse code=%0d addr=%h, expected none", phase, cmd_code, cmd_addr);
      end else begin
        got = exq.pop_front();
        if (cmd_code !== got.code || cmd_addr !== got.addr ||
            cmd_data !== got.data || cmd_sector !== got.sect) begin
          mismatched++;
          $display("FAIL %s: got code=%0d addr=%h data=%h sect=%h, expected code=%0d addr=%h data=%h sect=%h",
                   phase, cmd_code, cmd_addr, cmd_data, cmd_sector, got.code, got.addr, got.data, got.sect);
        end
      end
    end
  end

  task automatic push(input logic [2:0] c, input logic [19:0] a, input logic [7:0] d);
    exp_t e;
    e.code = c; e.addr = a; e.data = d; e.sect = a[19:16];
    exq.push_back(e);
  endtask

  task automatic wr(input logic [19:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic unlock();
    wr(20'h00555, 8'hAA);
    wr(20'h002AA, 8'h55);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drain(input string tag);
    repeat (2) @(negedge clk);
    chk({tag, " queue drained"}, exq.size(), 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R12 reset state
    chk("R12 valid", cmd_valid, 0);
    chk("R12 autosel", in_autoselect, 0);
    chk("R12 susp", erase_suspended, 0);
    chk("R12 addr", cmd_addr, 0);

    // R1 R4: prefix with upper bits set, program data F0h
    phase = "R1/R4";
    wr(20'hF0555, 8'hAA);
    wr(20'h7A2AA, 8'h55);
    wr(20'h3F555, 8'hA0);
    push(3'd2, 20'h12345, 8'hF0);
    wr(20'h12345, 8'hF0);
    drain("R4");

    // R8: busy after program ignores everything
    phase = "R8";
    busy_in = 1'b1;
    wr(20'h00000, 8'hF0);
    wr(20'h00000, 8'hB0);
    wr(20'h00555, 8'hAA);
    busy_in = 1'b0;
    drain("R8");

    // R2 autoselect, R3 exit
    phase = "R2";
    unlock();
    push(3'd1, 20'h00555, 8'h90);
    wr(20'h00555, 8'h90);
    drain("R2");
    chk("R2 autosel set", in_autoselect, 1);
    unlock();
    wr(20'h00555, 8'hA0);
    wr(20'h00010, 8'h22);
    drain("R2 ignored");
    chk("R2 autosel held", in_autoselect, 1);
    phase = "R3";
    push(3'd0, 20'hABCDE, 8'hF0);
    wr(20'hABCDE, 8'hF0);
    drain("R3");
    chk("R3 autosel clear", in_autoselect, 0);

    // R7 mismatches, then R5 chip erase
    phase = "R7";
    wr(20'h00555, 8'hAA);
    wr(20'h00555, 8'h55);
    wr(20'h002AA, 8'h55);
    wr(20'h00555, 8'hA0);
    wr(20'h00020, 8'h77);
    drain("R7");
    phase = "R5";
    unlock(); wr(20'h00555, 8'h80); unlock();
    push(3'd3, 20'h00555, 8'h10);
    wr(20'h00555, 8'h10);
    drain("R5");

    // R3 abort mid-erase
    phase = "R3 abort";
    unlock(); wr(20'h00555, 8'h80); wr(20'h00555, 8'hAA);
    push(3'd0, 20'h00000, 8'hF0);
    wr(20'h00000, 8'hF0);
    wr(20'h002AA, 8'h55);
    wr(20'h40000, 8'h30);
    drain("R3 abort");

    // R6 sector erase, R9 suspend
    phase = "R6";
    unlock(); wr(20'h00555, 8'h80); unlock();
    push(3'd4, 20'hB1234, 8'h30);
    wr(20'hB1234, 8'h30);
    drain("R6");
    phase = "R9";
    busy_in = 1'b1;
    wr(20'h00555, 8'hA0);
    wr(20'h00000, 8'hF0);
    push(3'd5, 20'h00001, 8'hB0);
    wr(20'h00001, 8'hB0);
    busy_in = 1'b0;
    drain("R9");
    chk("R9 suspended", erase_suspended, 1);

    // R10 behaviour while suspended
    phase = "R10";
    unlock(); wr(20'h00555, 8'h90);
    drain("R10 autosel blocked");
    chk("R10 no autosel", in_autoselect, 0);
    unlock(); wr(20'h00555, 8'hA0);
    push(3'd2, 20'h20040, 8'h5A);
    wr(20'h20040, 8'h5A);
    busy_in = 1'b1;
    wr(20'h00000, 8'hB0);
    busy_in = 1'b0;
    drain("R10 program");
    push(3'd6, 20'h9ABCD, 8'h30);
    wr(20'h9ABCD, 8'h30);
    drain("R10 resume");
    chk("R10 resumed", erase_suspended, 0);
    busy_in = 1'b1;
    push(3'd5, 20'h00000, 8'hB0);
    wr(20'h00000, 8'hB0);
    busy_in = 1'b0;
    drain("R9 second");

    // R12 soft clear, alone and colliding with a completing write
    phase = "R12";
    @(negedge clk); soft_clr = 1'b1;
    @(negedge clk); soft_clr = 1'b0;
    chk("R12 soft susp", erase_suspended, 0);
    unlock(); wr(20'h00555, 8'hA0);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 20'h00123; wr_data = 8'h44; soft_clr = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; soft_clr = 1'b0;
    wr(20'h00456, 8'h66);
    drain("R12 collision");
    chk("R12 valid low", cmd_valid, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule